// File: doc/BRIEF.md
# Ring Command Queue Consumer

This block is the hardware side of a software-fed command ring. Commands sit in a small local memory as 16-byte entries, each made of two 64-bit words. Software places commands in the ring and then moves a producer pointer forward through a register write. The block fetches each entry in order through a memory read port and decodes the opcode in the low byte of the first word. It then moves its consumer pointer one slot forward. Software reads that pointer back from an output.

The ring occupies a window of the memory that starts at a programmable base. Its length is a power of two chosen by a log2 size register. Each pointer carries one wrap bit above the index, so a ring with equal indices can be told to be either empty or full. The invalidation opcodes do no work of their own: they are acknowledged at once and advance an invalidation counter. The prefetch opcode is a plain no-op. A sync command retires only after every earlier command has retired, and it produces a one-cycle completion pulse. An unrecognised opcode halts the queue with the consumer parked on the offending entry and raises an error flag.

Top module: `cmd_ring_consumer`

## Requirements
- R1: After reset the consumer pointer is 0, the error flag and the sync pulse are low, the invalidation counter is 0, the queue is disabled and the log2 size is 4.
- R2: Writing register address 1 sets the producer pointer to the written value masked to log2size+1 bits. The ring is empty only when producer and consumer match in index and wrap bit, and the block keeps consuming until the consumer equals the producer.
- R3: Entries are fetched only while bit 3 of the control register (address 0) is 1. While that bit is 0, a pending ring is left untouched.
- R4: The opcode is bits [7:0] of word 0, which is memory data bits [7:0]. Accepted opcodes are 0x01, 0x03, 0x04, 0x05, 0x06, 0x11, 0x20, 0x30 and 0x46. Each accepted command advances the consumer by one, modulo 2^(log2size+1).
- R5: Opcodes 0x03, 0x04, 0x05, 0x06, 0x11, 0x20 and 0x30 each add one to the invalidation counter. Opcodes 0x01 and 0x46 leave the counter unchanged.
- R6: When a sync (0x46) retires, the sync-done output is high for one cycle. In that same cycle the consumer already points one past the sync entry, so all earlier entries have retired.
- R7: Any other opcode stops consumption with the consumer left on that entry and sets the error flag. Writing the control register with bit 3 = 0 clears the flag. After re-enabling, the same entry is fetched again.
- R8: A producer write is ignored if it would make the occupancy (producer minus consumer, modulo 2^(log2size+1)) exceed 2^log2size, or if it would make the occupancy smaller than it currently is.
- R9: The memory read address is base (register address 2, MEM_AW bits) plus the consumer index (consumer AND (2^log2size - 1)), modulo 2^MEM_AW. Read data arrives one cycle after the read enable.
- R10: Writing the log2 size (register address 3) with a value from 0 to 4 sets the size, resets both pointers to 0 and clears the error flag. A larger value is ignored and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 producer, 2 base, 3 log2 size |
| regWrData | input | REG_W | Register write data |
| memRdEn | output | 1 | Ring memory read enable |
| memRdAddr | output | MEM_AW | Ring memory read address |
| memRdData | input | 2*WORD_W | Command entry, word 0 in the low half, valid one cycle after memRdEn |
| consPtr | output | IDX_W+1 | Consumer pointer (index plus wrap bit) |
| cmdErr | output | 1 | Unknown-opcode error flag |
| invalCount | output | CNT_W | Count of retired invalidation commands |
| syncDone | output | 1 | One-cycle pulse when a sync retires |

## Verification
The bench builds the block with its default parameters: a 64-entry memory window and a maximum ring of 16 entries. Before many of its random rounds it reprograms the log2 size anywhere from 0 to 4. The one- and two-entry rings then wrap and fill within a few commands, so the wrap bit, the full boundary and overfilled producer writes all come up often. The base is also drawn at random, so the read address wraps around the end of the 64-entry memory. Unknown opcodes are planted at random spots and repaired after each halt, which exercises the stop, the flag clear and the retry again and again.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

  localparam logic [7:0] OP_PREFETCH   = 8'h01;
  localparam logic [7:0] OP_INV_ENTRY  = 8'h03;
  localparam logic [7:0] OP_INV_ALL    = 8'h04;
  localparam logic [7:0] OP_INV_CTX    = 8'h05;
  localparam logic [7:0] OP_INV_ALLCTX = 8'h06;
  localparam logic [7:0] OP_TLB_ASID   = 8'h11;
  localparam logic [7:0] OP_TLB_EL2    = 8'h20;
  localparam logic [7:0] OP_TLB_NS     = 8'h30;
  localparam logic [7:0] OP_SYNC       = 8'h46;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_PROD = 2'd1;
  localparam logic [1:0] REG_BASE = 2'd2;
  localparam logic [1:0] REG_SIZE = 2'd3;
  localparam int         ENABLE_BIT = 3;

  typedef enum logic [1:0] {OPK_BAD, OPK_NOP, OPK_INVAL, OPK_SYNC} opKind_e;

  typedef struct packed {
    logic issueRd;
    logic retire;
    logic countInval;
    logic syncHit;
    logic markErr;
  } ctrlStrobe_t;

  function automatic opKind_e classifyOp(input logic [7:0] op);
    opKind_e k;
    case (op)
      OP_PREFETCH:                      k = OPK_NOP;
      OP_INV_ENTRY, OP_INV_ALL,
      OP_INV_CTX, OP_INV_ALLCTX,
      OP_TLB_ASID, OP_TLB_EL2, OP_TLB_NS: k = OPK_INVAL;
      OP_SYNC:                          k = OPK_SYNC;
      default:                          k = OPK_BAD;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
  import cmd_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        qEnable,
  input  logic        errFlag,
  input  logic        haveWork,
  input  logic        flushed,
  input  logic [7:0]  opcode,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_DECODE} state_e;
  state_e state, stateNext;
  opKind_e kind;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    kind      = classifyOp(opcode);
    case (state)
      ST_IDLE: begin
        if (qEnable && !errFlag && haveWork) begin
          strobe.issueRd = 1'b1;
          stateNext      = ST_DECODE;
        end
      end
      ST_DECODE: begin
        stateNext = ST_IDLE;
        if (!flushed) begin
          case (kind)
            OPK_BAD:   strobe.markErr = 1'b1;
            OPK_NOP:   strobe.retire  = 1'b1;
            OPK_INVAL: begin
              strobe.retire     = 1'b1;
              strobe.countInval = 1'b1;
            end
            OPK_SYNC: begin
              strobe.retire  = 1'b1;
              strobe.syncHit = 1'b1;
            end
            default:   strobe.markErr = 1'b1;
          endcase
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // R9
  retire_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.retire || strobe.markErr) |-> $past(strobe.issueRd))
    else $error("retire without a preceding fetch");

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.countInval, strobe.syncHit, strobe.markErr}))
    else $error("more than one decode outcome");

endmodule

// File: rtl/cmd_ring_datapath.sv
module cmd_ring_datapath
  import cmd_ring_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32,
  localparam int PTR_W = IDX_W + 1,
  localparam int LOG_W = $clog2(IDX_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  ctrlStrobe_t       strobe,
  output logic              qEnable,
  output logic              errFlag,
  output logic              haveWork,
  output logic              flushed,
  output logic [MEM_AW-1:0] memRdAddr,
  output logic [PTR_W-1:0]  consPtr,
  output logic [CNT_W-1:0]  invalCnt,
  output logic              syncDone
);

  logic [PTR_W-1:0]  prodPtr;
  logic [MEM_AW-1:0] baseAddr;
  logic [LOG_W-1:0]  logSize;
  logic [PTR_W-1:0]  wrapBit, ptrMask, idxMask;
  logic [PTR_W-1:0]  newProd, curDist, newDist;
  logic              ctrlWr, prodWr, baseWr, sizeWr, prodOk;
  logic              unusedWr;

  assign unusedWr = ^regWrData;

  assign wrapBit = PTR_W'(1) << logSize;
  assign ptrMask = PTR_W'((wrapBit << 1) - PTR_W'(1));
  assign idxMask = wrapBit - PTR_W'(1);

  assign ctrlWr = regWrEn && (regAddr == REG_CTRL);
  assign prodWr = regWrEn && (regAddr == REG_PROD);
  assign baseWr = regWrEn && (regAddr == REG_BASE);
  assign sizeWr = regWrEn && (regAddr == REG_SIZE) && (regWrData <= REG_W'(IDX_W));

  assign newProd = regWrData[PTR_W-1:0] & ptrMask;
  assign curDist = (prodPtr - consPtr) & ptrMask;
  assign newDist = (newProd - consPtr) & ptrMask;
  assign prodOk  = (newDist >= curDist) && (newDist <= wrapBit);

  assign haveWork  = (prodPtr != consPtr);
  assign memRdAddr = baseAddr + MEM_AW'(consPtr & idxMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qEnable  <= 1'b0;
      errFlag  <= 1'b0;
      flushed  <= 1'b0;
      prodPtr  <= '0;
      consPtr  <= '0;
      baseAddr <= '0;
      logSize  <= LOG_W'(IDX_W);
      invalCnt <= '0;
      syncDone <= 1'b0;
    end else begin
      flushed  <= 1'b0;
      syncDone <= strobe.syncHit;
      if (ctrlWr) begin
        qEnable <= regWrData[ENABLE_BIT];
        if (!regWrData[ENABLE_BIT]) errFlag <= 1'b0;
      end
      if (baseWr)            baseAddr <= regWrData[MEM_AW-1:0];
      if (prodWr && prodOk)  prodPtr  <= newProd;
      if (strobe.retire)     consPtr  <= (consPtr + PTR_W'(1)) & ptrMask;
      if (strobe.markErr)    errFlag  <= 1'b1;
      if (strobe.countInval) invalCnt <= invalCnt + CNT_W'(1);
      if (sizeWr) begin
        logSize <= regWrData[LOG_W-1:0];
        prodPtr <= '0;
        consPtr <= '0;
        errFlag <= 1'b0;
        flushed <= 1'b1;
      end
    end
  end

  // R8
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    curDist <= wrapBit)
    else $error("ring occupancy above its size");

  // R2
  retire_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.retire |-> (prodPtr != consPtr))
    else $error("retire on an empty ring");

  // R7
  err_holds_cons_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && $past(errFlag)) |-> $stable(consPtr))
    else $error("consumer moved while halted");

  // R6
  sync_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syncDone |=> !syncDone)
    else $error("sync pulse longer than a cycle");

endmodule

// File: rtl/cmd_ring_consumer.sv
module cmd_ring_consumer
  import cmd_ring_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int IDX_W  = 4,
  parameter int WORD_W = 64,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32,
  localparam int PTR_W = IDX_W + 1,
  localparam int CMD_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memRdAddr,
  input  logic [CMD_W-1:0]  memRdData,
  output logic [PTR_W-1:0]  consPtr,
  output logic              cmdErr,
  output logic [CNT_W-1:0]  invalCount,
  output logic              syncDone
);

  ctrlStrobe_t strobe;
  logic        qEnable, haveWork, flushed;
  logic        unusedCmdBits;

  assign unusedCmdBits = ^memRdData[CMD_W-1:8];
  assign memRdEn       = strobe.issueRd;

  cmd_ring_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .qEnable  (qEnable),
    .errFlag  (cmdErr),
    .haveWork (haveWork),
    .flushed  (flushed),
    .opcode   (memRdData[7:0]),
    .strobe   (strobe)
  );

  cmd_ring_datapath #(
    .MEM_AW (MEM_AW),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobe    (strobe),
    .qEnable   (qEnable),
    .errFlag   (cmdErr),
    .haveWork  (haveWork),
    .flushed   (flushed),
    .memRdAddr (memRdAddr),
    .consPtr   (consPtr),
    .invalCnt  (invalCount),
    .syncDone  (syncDone)
  );

endmodule

// File: tb/cmd_ring_consumer_tb.sv
module cmd_ring_consumer_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         regWrEn = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic [31:0]  regWrData = '0;
  logic         memRdEn;
  logic [5:0]   memRdAddr;
  logic [127:0] memRdData = '0;
  logic [4:0]   consPtr;
  logic         cmdErr;
  logic [15:0]  invalCount;
  logic         syncDone;

  logic [127:0] mem [64];

  int vectors = 0, misses = 0, syncSeen = 0, lastSyncCons = -1;
  int mCons = 0, mProd = 0, mL = 4, mBase = 0, mInval = 0, mSync = 0, mLastSync = -1;
  int mErrIdx = 0;
  bit mErr = 0, finished = 0;

  always #10 clk = ~clk;

  cmd_ring_consumer u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .consPtr(consPtr), .cmdErr(cmdErr),
    .invalCount(invalCount), .syncDone(syncDone)
  );

  always @(posedge clk) if (memRdEn) memRdData <= mem[memRdAddr];

  always @(negedge clk) if (rst_n && syncDone) begin
    syncSeen++;
    lastSyncCons = int'(consPtr);
  end

  function automatic bit isValid(input logic [7:0] op);
    return op inside {8'h01, 8'h03, 8'h04, 8'h05, 8'h06, 8'h11, 8'h20, 8'h30, 8'h46};
  endfunction

  function automatic bit isInval(input logic [7:0] op);
    return op inside {8'h03, 8'h04, 8'h05, 8'h06, 8'h11, 8'h20, 8'h30};
  endfunction

  function automatic logic [7:0] randOp();
    logic [7:0] good [9] = '{8'h01, 8'h03, 8'h04, 8'h05, 8'h06, 8'h11, 8'h20, 8'h30, 8'h46};
    logic [7:0] bad  [4] = '{8'h00, 8'h02, 8'h47, 8'hFF};
    int r = int'($urandom % 16);
    if (r == 0) return bad[$urandom % 4];
    return good[$urandom % 9];
  endfunction

  function automatic int slotAddr(input int ptr);
    return (mBase + (ptr & ((1 << mL) - 1))) & 63;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input int d);
    regWrEn = 1'b1; regAddr = a; regWrData = 32'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (45) @(negedge clk);
  endtask

  task automatic putOp(input int ptr, input logic [7:0] op);
    mem[slotAddr(ptr)] = {$urandom, $urandom, $urandom, $urandom} & ~128'hFF | 128'(op);
  endtask

  task automatic modelRun();
    int pm = (1 << (mL + 1)) - 1;
    while (mCons != mProd && !mErr) begin
      logic [7:0] op = mem[slotAddr(mCons)][7:0];
      if (!isValid(op)) begin
        mErr = 1; mErrIdx = mCons;
      end else begin
        if (isInval(op)) mInval = (mInval + 1) & 16'hFFFF;
        mCons = (mCons + 1) & pm;
        if (op == 8'h46) begin mSync++; mLastSync = mCons; end
      end
    end
  endtask

  task automatic compareAll(input string tag);
    check({tag, " R4 R9 consumer"}, int'(consPtr), mCons);
    check({tag, " R7 error flag"}, int'(cmdErr), int'(mErr));
    check({tag, " R5 inval count"}, int'(invalCount), mInval);
    check({tag, " R6 sync count"}, syncSeen, mSync);
  endtask

  task automatic repairIfHalted();
    if (mErr) begin
      regWrite(2'd0, 0);
      check("R7 flag cleared by disable", int'(cmdErr), 0);
      mErr = 0;
      mem[slotAddr(mErrIdx)][7:0] = 8'h04;
      regWrite(2'd0, 8);
      settle();
      modelRun();
      compareAll("retry");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 64; i++) mem[i] = 128'h04;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 consumer", int'(consPtr), 0);
    check("R1 error", int'(cmdErr), 0);
    check("R1 count", int'(invalCount), 0);
    check("R1 sync", int'(syncDone), 0);

    // R3: disabled queue does not drain
    putOp(0, 8'h03); putOp(1, 8'h01); putOp(2, 8'h30);
    regWrite(2'd1, 3); mProd = 3;
    settle();
    check("R3 disabled consumer", int'(consPtr), 0);
    check("R3 disabled count", int'(invalCount), 0);
    regWrite(2'd0, 8);
    settle(); modelRun(); compareAll("R3 enabled");

    // R8 / R2: fill the whole ring, wrap bit set, overfill and backward ignored
    regWrite(2'd0, 0);
    for (int k = 0; k < 16; k++) putOp(3 + k, 8'h11);
    putOp(18, 8'h46);
    regWrite(2'd1, 19);
    regWrite(2'd1, 20);
    regWrite(2'd1, 10);
    mProd = 19;
    regWrite(2'd0, 8);
    settle(); modelRun(); compareAll("R8 full ring");
    check("R2 wrap bit", int'(consPtr[4]), 1);
    check("R6 consumer at sync pulse", lastSyncCons, 19);

    // R7 directed halt
    putOp(19, 8'h02); putOp(20, 8'h05);
    regWrite(2'd1, 21); mProd = 21;
    settle(); modelRun(); compareAll("R7 halt");
    check("R7 parked on bad entry", int'(consPtr), 19);
    repairIfHalted();

    // R10: out-of-range size ignored, valid size resets pointers
    regWrite(2'd3, 7);
    @(negedge clk);
    check("R10 bad size keeps consumer", int'(consPtr), mCons);
    regWrite(2'd3, 2); mL = 2; mCons = 0; mProd = 0;
    @(negedge clk);
    check("R10 size resets consumer", int'(consPtr), 0);

    for (int it = 0; it < 40; it++) begin
      int size, n, newP;
      if ($urandom % 4 == 0) begin
        mL = int'($urandom % 5);
        regWrite(2'd3, mL); mCons = 0; mProd = 0;
        check("R10 reconfig consumer", int'(consPtr), 0);
      end
      mBase = int'($urandom % 64);
      regWrite(2'd2, mBase);
      size = 1 << mL;
      for (int k = 0; k < size; k++) putOp(mCons + k, randOp());
      n = int'($urandom % (size + 2));
      newP = (mCons + n) & ((1 << (mL + 1)) - 1);
      regWrite(2'd1, newP);
      if (n <= size) mProd = newP;
      settle(); modelRun(); compareAll("random");
      repairIfHalted();
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule